// File: doc/BRIEF.md
# Shared-Memory Mailbox Interrupt Controller

This block sits beside a 16K-word, two-port shared memory and produces one interrupt line per port. Each port owns a mailbox word at the top of the address space: port A owns the word at the second-highest address and port B owns the highest word. When one port writes into the other port's mailbox, the owner's interrupt line goes low on the next clock. The owner acknowledges the interrupt by reading its own mailbox word, and that read returns the interrupt line high.

The mailbox words hold an ordinary 16-bit message. The message is stored in the memory array, which is outside this block. This block only watches the chip-select, write-strobe, output-enable and address inputs of both ports. A global enable input turns the mailbox behaviour off. While it is off, the two top words are plain storage and neither line can go low.

Top module: `mbox_irq`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, both a_irq_n and b_irq_n are 1 (deasserted).
- R2: With irq_en high, a port-B write (b_sel_n=0, b_wr_n=0, b_addr=0x3FFE) drives a_irq_n to 0 after the next rising clock edge.
- R3: With irq_en high, a port-A write (a_sel_n=0, a_wr_n=0, a_addr=0x3FFF) drives b_irq_n to 0 after the next rising clock edge.
- R4: With irq_en high, a port-A access with a_sel_n=0, a_oe_n=0 and a_addr=0x3FFE returns a_irq_n to 1 after the next edge. The value of a_wr_n does not matter for this.
- R5: With irq_en high, a port-B access with b_sel_n=0, b_oe_n=0 and b_addr=0x3FFF returns b_irq_n to 1 after the next edge.
- R6: When the set condition and the clear condition for the same line occur in the same cycle, the line is 0 after that edge.
- R7: While irq_en is low, no access sets either line, and both lines are 1 after the next edge.
- R8: A line keeps its value when neither its set nor its clear condition occurs. This includes an access to another address, a deselected access (sel_n=1), and a port writing its own mailbox.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_en | input | 1 | Mailbox interrupt function enable |
| a_sel_n | input | 1 | Port A chip select, active low |
| a_wr_n | input | 1 | Port A write strobe, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_addr | input | 14 | Port A word address |
| b_sel_n | input | 1 | Port B chip select, active low |
| b_wr_n | input | 1 | Port B write strobe, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_addr | input | 14 | Port B word address |
| a_irq_n | output | 1 | Interrupt toward port A, active low, registered |
| b_irq_n | output | 1 | Interrupt toward port B, active low, registered |

## Verification
The bench aims at the decode corners where a faulty design behaves differently.

- **Same-cycle set and clear:** the owner reads while the peer writes. A design that gives the clear priority would drop an incoming message.
- **Own-mailbox write:** a port writes its own mailbox. A design that decodes the wrong port would raise or clear the wrong line.
- **Acknowledge with the write strobe low:** a design that requires a pure read would leave the line stuck low.
- **Disable in the middle of a pending interrupt:** a design that gated only the set would keep the line low.
- **Randomized traffic:** this phase is biased toward the two mailbox addresses. It checks that neighbouring addresses and deselected cycles never change a line.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;
   // one flag update request produced by the decoders
   typedef struct packed {
      logic set;
      logic clr;
   } flag_req_t;

   // index of each port in the per-port arrays
   localparam int PORT_A = 0;
   localparam int PORT_B = 1;
   localparam int NUM_PORTS = 2;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode #(
   parameter int ADDR_W = 14,
   parameter logic [ADDR_W-1:0] OWN_BOX = '1,
   parameter logic [ADDR_W-1:0] PEER_BOX = '1
) (
   input  logic              sel_n,
   input  logic              wr_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              wr_peer,
   output logic              rd_own
);
   if (OWN_BOX == PEER_BOX) begin : g_bad_box
      $error("mbox_decode: mailbox addresses must differ");
   end

   logic active;
   assign active  = ~sel_n;
   // a write into the mailbox that belongs to the other port
   assign wr_peer = active & ~wr_n & (addr == PEER_BOX);
   // an output-enabled access of the own mailbox; write strobe is ignored
   assign rd_own  = active & ~oe_n & (addr == OWN_BOX);
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  mbox_irq_pkg::flag_req_t req,
   output logic flag_n
);
   logic pend_q;
   logic pend_d;

   if (SET_WINS) begin : g_set_prio
      assign pend_d = req.set | (pend_q & ~req.clr);
   end else begin : g_clr_prio
      assign pend_d = (pend_q | req.set) & ~req.clr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       pend_q <= 1'b0;
      else if (!enable) pend_q <= 1'b0;
      else              pend_q <= pend_d;
   end

   assign flag_n = ~pend_q;
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq #(
   parameter int ADDR_W   = 14,
   parameter bit IRQ_IMPL = 1'b1,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_en,
   input  logic              a_sel_n,
   input  logic              a_wr_n,
   input  logic              a_oe_n,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic              b_sel_n,
   input  logic              b_wr_n,
   input  logic              b_oe_n,
   input  logic [ADDR_W-1:0] b_addr,
   output logic              a_irq_n,
   output logic              b_irq_n
);
   import mbox_irq_pkg::*;

   // port A owns the second-highest word, port B the highest
   localparam logic [ADDR_W-1:0] BOX_A = {{(ADDR_W-1){1'b1}}, 1'b0};
   localparam logic [ADDR_W-1:0] BOX_B = {ADDR_W{1'b1}};

   if (ADDR_W < 2) begin : g_bad_width
      $error("mbox_irq: ADDR_W must be at least 2");
   end

   logic [NUM_PORTS-1:0] sel_n_v, wr_n_v, oe_n_v;
   logic [ADDR_W-1:0]    addr_v [NUM_PORTS];
   logic [NUM_PORTS-1:0] wr_peer, rd_own, irq_n_v;

   assign sel_n_v = {b_sel_n, a_sel_n};
   assign wr_n_v  = {b_wr_n, a_wr_n};
   assign oe_n_v  = {b_oe_n, a_oe_n};
   assign addr_v[PORT_A] = a_addr;
   assign addr_v[PORT_B] = b_addr;

   if (IRQ_IMPL) begin : g_irq
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         localparam logic [ADDR_W-1:0] OWN  = (p == PORT_A) ? BOX_A : BOX_B;
         localparam logic [ADDR_W-1:0] PEER = (p == PORT_A) ? BOX_B : BOX_A;
         flag_req_t req;

         mbox_decode #(.ADDR_W(ADDR_W), .OWN_BOX(OWN), .PEER_BOX(PEER)) u_dec (
            .sel_n  (sel_n_v[p]),
            .wr_n   (wr_n_v[p]),
            .oe_n   (oe_n_v[p]),
            .addr   (addr_v[p]),
            .wr_peer(wr_peer[p]),
            .rd_own (rd_own[p])
         );

         // set comes from the opposite port, clear from this port
         assign req.set = wr_peer[NUM_PORTS-1-p];
         assign req.clr = rd_own[p];

         mbox_flag #(.SET_WINS(SET_WINS)) u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .enable(irq_en),
            .req   (req),
            .flag_n(irq_n_v[p])
         );
      end
   end else begin : g_no_irq
      assign wr_peer = '0;
      assign rd_own  = '0;
      assign irq_n_v = '1;
   end

   assign a_irq_n = irq_n_v[PORT_A];
   assign b_irq_n = irq_n_v[PORT_B];
endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
   parameter int ADDR_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq_en,
   input logic              a_sel_n,
   input logic              a_wr_n,
   input logic              a_oe_n,
   input logic [ADDR_W-1:0] a_addr,
   input logic              b_sel_n,
   input logic              b_wr_n,
   input logic              b_oe_n,
   input logic [ADDR_W-1:0] b_addr,
   input logic              a_irq_n,
   input logic              b_irq_n
);
   localparam logic [ADDR_W-1:0] BOX_A = {{(ADDR_W-1){1'b1}}, 1'b0};
   localparam logic [ADDR_W-1:0] BOX_B = {ADDR_W{1'b1}};

   logic post_a, post_b, ack_a, ack_b;
   assign post_a = !b_sel_n && !b_wr_n && (b_addr == BOX_A);
   assign post_b = !a_sel_n && !a_wr_n && (a_addr == BOX_B);
   assign ack_a  = !a_sel_n && !a_oe_n && (a_addr == BOX_A);
   assign ack_b  = !b_sel_n && !b_oe_n && (b_addr == BOX_B);

   AST_SET_A: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && post_a) |=> !a_irq_n); // R2
   AST_SET_B: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && post_b) |=> !b_irq_n); // R3
   AST_CLR_A: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && ack_a && !post_a) |=> a_irq_n); // R4
   AST_CLR_B: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && ack_b && !post_b) |=> b_irq_n); // R5
   AST_SET_WINS_A: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && post_a && ack_a) |=> !a_irq_n); // R6
   AST_SET_WINS_B: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && post_b && ack_b) |=> !b_irq_n); // R6
   AST_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |=> (a_irq_n && b_irq_n)); // R7
   AST_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && !post_a && !ack_a) |=> $stable(a_irq_n)); // R8
   AST_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && !post_b && !ack_b) |=> $stable(b_irq_n)); // R8
endmodule

bind mbox_irq mbox_irq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_mbox_irq.sv
`timescale 1ns/1ps
module tb_mbox_irq;
   localparam int AW = 14;
   localparam logic [AW-1:0] BOX_A = 14'h3FFE;
   localparam logic [AW-1:0] BOX_B = 14'h3FFF;

   logic clk = 1'b0;
   logic rst_n, irq_en;
   logic a_sel_n, a_wr_n, a_oe_n, b_sel_n, b_wr_n, b_oe_n;
   logic [AW-1:0] a_addr, b_addr;
   logic a_irq_n, b_irq_n;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   string phase = "R1";
   bit exp_a = 1'b0;   // 1 = interrupt pending toward port A
   bit exp_b = 1'b0;

   always #2 clk = ~clk;

   mbox_irq dut (.*);

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic idle();
      a_sel_n = 1; a_wr_n = 1; a_oe_n = 1; a_addr = '0;
      b_sel_n = 1; b_wr_n = 1; b_oe_n = 1; b_addr = '0;
   endtask

   task automatic drive_a(bit s, bit w, bit o, logic [AW-1:0] ad);
      a_sel_n = s; a_wr_n = w; a_oe_n = o; a_addr = ad;
   endtask

   task automatic drive_b(bit s, bit w, bit o, logic [AW-1:0] ad);
      b_sel_n = s; b_wr_n = w; b_oe_n = o; b_addr = ad;
   endtask

   // one clock: update the reference from the inputs, then compare
   task automatic cyc();
      bit sa, sb, ca, cb;
      @(posedge clk);
      #0.5;
      if (!rst_n || !irq_en) begin
         exp_a = 0; exp_b = 0;
      end else begin
         sa = (b_sel_n == 0) && (b_wr_n == 0) && (b_addr == BOX_A);
         sb = (a_sel_n == 0) && (a_wr_n == 0) && (a_addr == BOX_B);
         ca = (a_sel_n == 0) && (a_oe_n == 0) && (a_addr == BOX_A);
         cb = (b_sel_n == 0) && (b_oe_n == 0) && (b_addr == BOX_B);
         exp_a = sa ? 1'b1 : (ca ? 1'b0 : exp_a);
         exp_b = sb ? 1'b1 : (cb ? 1'b0 : exp_b);
      end
      @(negedge clk);
      checks++;
      if (a_irq_n !== !exp_a || b_irq_n !== !exp_b) begin
         errors++;
         $display("FAIL %s: a_irq_n=%b b_irq_n=%b expected %b %b",
                  phase, a_irq_n, b_irq_n, !exp_a, !exp_b);
      end
   endtask

   initial begin
      rst_n = 0; irq_en = 1; idle();
      // R1: reset state, even with a posting write present
      phase = "R1 reset";
      drive_b(0, 0, 1, BOX_A);
      repeat (3) cyc();
      idle(); rst_n = 1;
      cyc();

      phase = "R2 set A"; drive_b(0, 0, 1, BOX_A); cyc();
      idle(); phase = "R8 hold A"; cyc();
      phase = "R8 own write"; drive_a(0, 0, 1, BOX_A); cyc();
      phase = "R8 other addr"; drive_a(0, 1, 0, 14'h3FFD); cyc();
      phase = "R8 deselected"; drive_a(1, 1, 0, BOX_A); cyc();
      phase = "R8 peer read"; idle(); drive_b(0, 1, 0, BOX_A); cyc();
      idle();
      phase = "R4 clear A wr low"; drive_a(0, 0, 0, BOX_A); cyc();
      phase = "R2 set A again"; idle(); drive_b(0, 0, 1, BOX_A); cyc();
      phase = "R4 clear A read"; idle(); drive_a(0, 1, 0, BOX_A); cyc();

      phase = "R3 set B"; idle(); drive_a(0, 0, 1, BOX_B); cyc();
      phase = "R8 own write B"; idle(); drive_b(0, 0, 1, BOX_B); cyc();
      phase = "R5 clear B"; idle(); drive_b(0, 1, 0, BOX_B); cyc();

      phase = "R6 set wins A"; idle();
      drive_b(0, 0, 1, BOX_A); drive_a(0, 1, 0, BOX_A); cyc();
      phase = "R6 set wins B"; idle();
      drive_a(0, 0, 1, BOX_B); drive_b(0, 1, 0, BOX_B); cyc();

      phase = "R7 disable clears"; idle(); irq_en = 0; cyc();
      phase = "R7 no set while off";
      drive_b(0, 0, 1, BOX_A); drive_a(0, 0, 1, BOX_B); cyc(); cyc();
      idle(); irq_en = 1; cyc();

      phase = "R8 random";
      for (int i = 0; i < 4000; i++) begin
         a_sel_n = 1'($urandom_range(0, 3) == 0);
         a_wr_n  = 1'($urandom_range(0, 1));
         a_oe_n  = 1'($urandom_range(0, 1));
         a_addr  = ($urandom_range(0, 3) == 0) ? AW'($urandom) :
                   14'h3FFC + AW'($urandom_range(0, 3));
         b_sel_n = 1'($urandom_range(0, 3) == 0);
         b_wr_n  = 1'($urandom_range(0, 1));
         b_oe_n  = 1'($urandom_range(0, 1));
         b_addr  = ($urandom_range(0, 3) == 0) ? AW'($urandom) :
                   14'h3FFC + AW'($urandom_range(0, 3));
         irq_en  = ($urandom_range(0, 31) != 0);
         cyc();
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule